// File: doc/BRIEF.md
# Maskable Interrupt Acknowledge Bus Sequencer

This block is the bus-cycle state machine of an 8-bit CPU bus interface that handles the maskable interrupt. At every instruction boundary it decides whether a pending request may be taken. When it takes one, it runs an acknowledge cycle shaped like an opcode fetch, with two differences. The I/O strobe takes the place of the memory strobe, and automatic wait states give a daisy-chained priority network time to settle. At the end of those wait states it captures the 8-bit response vector from the data bus. A refresh phase follows, and it increments the refresh counter.

Each clock period is one T-state. The instruction decoder pulses `end_instr` during the last T-state of every instruction. The block then samples the request together with the bus-request line and its own enable flag. Outside an acknowledge cycle the bus strobes stay low (all strobes are active high here), and the program counter is driven on the address bus.

Top module: `irq_ack_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, all bus strobes and `vec_valid` are 0, `ie_flag` is 0 and `rfsh_val` is 0.
- R2: A request is taken only on a rising edge where `end_instr`, `int_req` and `ie_flag` are 1 and `busreq` is 0. The cycle after that edge is the first T-state (T1) of the acknowledge cycle.
- R3: With `ie_flag` at 0, an instruction boundary with `int_req` at 1 starts no acknowledge cycle and leaves `ie_flag` at 0.
- R4: With `busreq` at 1 at the sampling edge, no acknowledge cycle starts and `ie_flag` stays 1.
- R5: In T1 and T2, `bus_m1` is 1, `addr` equals `pc`, and `bus_mreq`, `bus_iorq` and `bus_rfsh` are 0.
- R6: Exactly AUTO_WAITS (default 2) wait states follow T2 whatever the level of `wait_n`. In each of them `bus_m1` and `bus_iorq` are 1, `addr` equals `pc` and `bus_mreq` is 0.
- R7: If `wait_n` is 0 at the end of the last automatic wait state, further wait states with the same strobes follow until `wait_n` is sampled 1.
- R8: `data_in` is captured at the edge that ends the final wait state. `vec_valid` is 1 for exactly the following cycle (T3), and `vec_out` holds the value afterwards.
- R9: T3 and T4 each last one cycle. In both, `bus_rfsh` and `bus_mreq` are 1, `bus_m1` and `bus_iorq` are 0, and `addr` is `{rfsh_page, rfsh_val}`. The cycle after T4 is idle.
- R10: `bus_rd` stays 0 throughout, and `bus_mreq` and `bus_iorq` are never 1 together.
- R11: Taking a request clears `ie_flag`. `ie_set` sets it and `ie_clr` clears it at the next edge.
- R12: At the edge ending T4, the low 7 bits of `rfsh_val` increment and wrap, and bit 7 keeps its value. `rfsh_load` writes `rfsh_load_val` at the next edge.
- R13: `int_req` at 1 in cycles where `end_instr` is 0 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per period |
| rst_n | input | 1 | Synchronous reset, active low |
| end_instr | input | 1 | High in the last T-state of an instruction |
| int_req | input | 1 | Maskable interrupt request, active high |
| busreq | input | 1 | External bus request pending, active high |
| ie_set | input | 1 | Set the interrupt-enable flag |
| ie_clr | input | 1 | Clear the interrupt-enable flag |
| pc | input | 16 | Program counter |
| wait_n | input | 1 | Ready input, low requests extra wait states |
| data_in | input | 8 | Data bus input |
| rfsh_load | input | 1 | Load the refresh counter |
| rfsh_load_val | input | 8 | Value for the refresh counter load |
| rfsh_page | input | 8 | Upper address byte used during refresh |
| addr | output | 16 | Address bus |
| bus_m1 | output | 1 | Fetch-cycle marker |
| bus_mreq | output | 1 | Memory request strobe |
| bus_iorq | output | 1 | I/O request strobe |
| bus_rd | output | 1 | Read strobe |
| bus_rfsh | output | 1 | Refresh strobe |
| vec_out | output | 8 | Captured response vector |
| vec_valid | output | 1 | One-cycle pulse when a vector is captured |
| ie_flag | output | 1 | Interrupt-enable flag |
| rfsh_val | output | 8 | Refresh counter |

## Verification
The assertions assume that `end_instr` is a single-cycle strobe that the decoder raises only while no acknowledge cycle is running. They also assume that `rfsh_load` is not asserted in the cycle that ends T4. The stimulus raises `end_instr` only from the idle state, and for one cycle at a time. It loads the refresh counter only from idle, and it holds `wait_n` low in the first automatic wait state to show that the level is ignored there. The sweeps cover every combination of request, enable flag and bus request, and zero to three extra wait states. They also cover refresh values on both sides of the 7-bit wrap.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_TWA  = 3'd3,
      ST_TWX  = 3'd4,
      ST_T3   = 3'd5,
      ST_T4   = 3'd6
   } ack_state_t;

   typedef struct packed {
      logic m1;
      logic mreq;
      logic iorq;
      logic rd;
      logic rfsh;
   } bus_strobe_t;

endpackage

// File: rtl/irq_accept_gate.sv
module irq_accept_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic idle,
   input  logic end_instr,
   input  logic int_req,
   input  logic busreq,
   input  logic ie_set,
   input  logic ie_clr,
   output logic take,
   output logic ie_flag
);

   assign take = idle & end_instr & int_req & ie_flag & ~busreq;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ie_flag <= 1'b0;
      else if (take || ie_clr)
         ie_flag <= 1'b0;
      else if (ie_set)
         ie_flag <= 1'b1;
   end

   // R11
   ie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !ie_flag);

   // R4
   busreq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busreq |-> !take);

endmodule

// File: rtl/ack_cycle_fsm.sv
module ack_cycle_fsm
   import irq_ack_pkg::*;
#(
   parameter int AUTO_WAITS = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take,
   input  logic       wait_n,
   output ack_state_t state,
   output logic       latch_vec,
   output logic       rfsh_step
);

   localparam int CW = (AUTO_WAITS > 1) ? $clog2(AUTO_WAITS) : 1;
   localparam logic [CW-1:0] WLAST = CW'(AUTO_WAITS - 1);

   logic [CW-1:0] wcnt;
   logic          wlast;

   assign wlast     = (wcnt == WLAST);
   assign latch_vec = wait_n & (((state == ST_TWA) & wlast) | (state == ST_TWX));
   assign rfsh_step = (state == ST_T4);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         wcnt  <= '0;
      end else begin
         case (state)
            ST_IDLE: if (take) state <= ST_T1;
            ST_T1:   state <= ST_T2;
            ST_T2: begin
               state <= ST_TWA;
               wcnt  <= '0;
            end
            ST_TWA: begin
               if (!wlast)
                  wcnt <= wcnt + 1'b1;
               else if (wait_n)
                  state <= ST_T3;
               else
                  state <= ST_TWX;
            end
            ST_TWX:  if (wait_n) state <= ST_T3;
            ST_T3:   state <= ST_T4;
            ST_T4:   state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R6
   auto_wait_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_T2) |=> (state == ST_TWA));

   // R7
   hold_on_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TWX && !wait_n) |=> (state == ST_TWX));

   // R9
   refresh_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_T3) |=> (state == ST_T4));

endmodule

// File: rtl/refresh_counter.sv
module refresh_counter #(
   parameter int RFSH_W     = 8,
   parameter int RFSH_INC_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [RFSH_W-1:0] load_val,
   input  logic              step,
   output logic [RFSH_W-1:0] cnt
);

   logic [RFSH_W-1:0] nxt;

   generate
      if (RFSH_INC_W == RFSH_W) begin : g_full
         assign nxt = cnt + 1'b1;
      end else begin : g_part
         logic [RFSH_INC_W-1:0] low_inc;
         assign low_inc = cnt[RFSH_INC_W-1:0] + 1'b1;
         assign nxt     = {cnt[RFSH_W-1:RFSH_INC_W], low_inc};

         // R12
         top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !load |=> $stable(cnt[RFSH_W-1]));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (step)
         cnt <= nxt;
   end

endmodule

// File: rtl/vector_capture.sv
module vector_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              latch,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] vec,
   output logic              valid
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec   <= '0;
         valid <= 1'b0;
      end else begin
         valid <= latch;
         if (latch)
            vec <= din;
      end
   end

   // R8
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
   import irq_ack_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int RFSH_W     = 8,
   parameter int RFSH_INC_W = 7,
   parameter int AUTO_WAITS = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     end_instr,
   input  logic                     int_req,
   input  logic                     busreq,
   input  logic                     ie_set,
   input  logic                     ie_clr,
   input  logic [ADDR_W-1:0]        pc,
   input  logic                     wait_n,
   input  logic [DATA_W-1:0]        data_in,
   input  logic                     rfsh_load,
   input  logic [RFSH_W-1:0]        rfsh_load_val,
   input  logic [ADDR_W-RFSH_W-1:0] rfsh_page,
   output logic [ADDR_W-1:0]        addr,
   output logic                     bus_m1,
   output logic                     bus_mreq,
   output logic                     bus_iorq,
   output logic                     bus_rd,
   output logic                     bus_rfsh,
   output logic [DATA_W-1:0]        vec_out,
   output logic                     vec_valid,
   output logic                     ie_flag,
   output logic [RFSH_W-1:0]        rfsh_val
);

   generate
      if (AUTO_WAITS < 1) begin : g_bad_waits
         $error("AUTO_WAITS must be at least 1");
      end
      if (RFSH_INC_W < 1 || RFSH_INC_W > RFSH_W) begin : g_bad_inc
         $error("RFSH_INC_W must lie in 1..RFSH_W");
      end
      if (RFSH_W >= ADDR_W) begin : g_bad_rfsh
         $error("RFSH_W must be narrower than ADDR_W");
      end
   endgenerate

   ack_state_t  state;
   logic        take;
   logic        latch_vec;
   logic        rfsh_step;
   bus_strobe_t strb;

   irq_accept_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .idle      (state == ST_IDLE),
      .end_instr (end_instr),
      .int_req   (int_req),
      .busreq    (busreq),
      .ie_set    (ie_set),
      .ie_clr    (ie_clr),
      .take      (take),
      .ie_flag   (ie_flag)
   );

   ack_cycle_fsm #(.AUTO_WAITS(AUTO_WAITS)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .wait_n    (wait_n),
      .state     (state),
      .latch_vec (latch_vec),
      .rfsh_step (rfsh_step)
   );

   refresh_counter #(.RFSH_W(RFSH_W), .RFSH_INC_W(RFSH_INC_W)) u_rfsh (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (rfsh_load),
      .load_val (rfsh_load_val),
      .step     (rfsh_step),
      .cnt      (rfsh_val)
   );

   vector_capture #(.DATA_W(DATA_W)) u_vec (
      .clk   (clk),
      .rst_n (rst_n),
      .latch (latch_vec),
      .din   (data_in),
      .vec   (vec_out),
      .valid (vec_valid)
   );

   always_comb begin
      strb = '0;
      addr = pc;
      case (state)
         ST_T1, ST_T2:   strb.m1 = 1'b1;
         ST_TWA, ST_TWX: begin
            strb.m1   = 1'b1;
            strb.iorq = 1'b1;
         end
         ST_T3, ST_T4: begin
            strb.mreq = 1'b1;
            strb.rfsh = 1'b1;
            addr      = {rfsh_page, rfsh_val};
         end
         default: strb = '0;
      endcase
   end

   assign bus_m1   = strb.m1;
   assign bus_mreq = strb.mreq;
   assign bus_iorq = strb.iorq;
   assign bus_rd   = strb.rd;
   assign bus_rfsh = strb.rfsh;

   // R10
   strobe_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_mreq && bus_iorq));

   // R2
   accept_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_m1) |-> ($past(end_instr) && $past(int_req) && !$past(busreq)));

   // R5
   iorq_after_m1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_iorq) |-> $past(bus_m1));

   // R9
   wait_to_rfsh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_iorq) |-> (bus_rfsh && vec_valid));

endmodule

// File: tb/test_irq_ack_seq.sv
module test_irq_ack_seq;

   logic        clk = 1'b0;
   logic        rst_n, end_instr, int_req, busreq, ie_set, ie_clr;
   logic [15:0] pc;
   logic        wait_n;
   logic [7:0]  data_in, rfsh_load_val, rfsh_page;
   logic        rfsh_load;
   logic [15:0] addr;
   logic        bus_m1, bus_mreq, bus_iorq, bus_rd, bus_rfsh;
   logic [7:0]  vec_out, rfsh_val;
   logic        vec_valid, ie_flag;

   int          n_chk  = 0;
   int          n_fail = 0;
   logic [7:0]  r_exp;

   always #5 clk = ~clk;

   irq_ack_seq i_irq_ack_seq (
      .clk(clk), .rst_n(rst_n), .end_instr(end_instr), .int_req(int_req),
      .busreq(busreq), .ie_set(ie_set), .ie_clr(ie_clr), .pc(pc),
      .wait_n(wait_n), .data_in(data_in), .rfsh_load(rfsh_load),
      .rfsh_load_val(rfsh_load_val), .rfsh_page(rfsh_page), .addr(addr),
      .bus_m1(bus_m1), .bus_mreq(bus_mreq), .bus_iorq(bus_iorq),
      .bus_rd(bus_rd), .bus_rfsh(bus_rfsh), .vec_out(vec_out),
      .vec_valid(vec_valid), .ie_flag(ie_flag), .rfsh_val(rfsh_val)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // strobes packed as {m1, mreq, iorq, rd, rfsh}
   function automatic logic [4:0] strobes();
      return {bus_m1, bus_mreq, bus_iorq, bus_rd, bus_rfsh};
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic enable_ie();
      ie_set = 1'b1;
      step();
      ie_set = 1'b0;
      check("R11 ie_set", ie_flag, 1);
   endtask

   task automatic run_ack(input int extra, input logic [15:0] pc_v, input logic [7:0] vec_v);
      pc        = pc_v;
      int_req   = 1'b1;
      end_instr = 1'b1;
      wait_n    = 1'b1;
      data_in   = 8'h00;
      step();
      end_instr = 1'b0;
      int_req   = 1'b0;
      check("R2 T1 entry", strobes(), 5'b10000);
      check("R5 T1 addr", addr, pc_v);
      check("R11 ie cleared", ie_flag, 0);
      step();
      check("R5 T2 strobes", strobes(), 5'b10000);
      check("R5 T2 addr", addr, pc_v);
      data_in = vec_v;
      for (int i = 0; i < 2 + extra; i++) begin
         step();
         check(i < 2 ? "R6 auto wait strobes" : "R7 extra wait strobes", strobes(), 5'b10100);
         check("R6 wait addr", addr, pc_v);
         check("R8 no early valid", vec_valid, 0);
         wait_n = (i == 1 + extra);
      end
      step();
      data_in = ~vec_v;
      wait_n  = 1'b1;
      check("R9 T3 strobes", strobes(), 5'b01001);
      check("R9 T3 addr", addr, {rfsh_page, r_exp});
      check("R8 valid pulse", vec_valid, 1);
      check("R8 vector", vec_out, vec_v);
      step();
      check("R9 T4 strobes", strobes(), 5'b01001);
      check("R9 T4 addr", addr, {rfsh_page, r_exp});
      check("R8 pulse ends", vec_valid, 0);
      step();
      r_exp = {r_exp[7], r_exp[6:0] + 7'd1};
      check("R9 idle after T4", strobes(), 5'b00000);
      check("R12 refresh step", rfsh_val, r_exp);
      check("R8 vector held", vec_out, vec_v);
      check("R10 rd low", bus_rd, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; end_instr = 1'b0; int_req = 1'b0; busreq = 1'b0;
      ie_set = 1'b0; ie_clr = 1'b0; pc = 16'h0000; wait_n = 1'b1;
      data_in = 8'h00; rfsh_load = 1'b0; rfsh_load_val = 8'h00; rfsh_page = 8'h3C;
      r_exp = 8'h00;
      repeat (3) step();
      check("R1 reset strobes", strobes(), 5'b00000);
      check("R1 reset ie", ie_flag, 0);
      check("R1 reset refresh", rfsh_val, 0);
      check("R1 reset valid", vec_valid, 0);
      rst_n = 1'b1;
      step();
      check("R1 after release", {strobes(), vec_valid, ie_flag}, 7'b0);

      // R13: request without an instruction boundary
      enable_ie();
      int_req = 1'b1;
      pc = 16'h1234;
      for (int k = 0; k < 4; k++) begin
         step();
         check("R13 no boundary", strobes(), 5'b00000);
         check("R13 ie kept", ie_flag, 1);
      end
      int_req = 1'b0;

      // R2, R3, R4: every rejected combination of request, enable, bus request
      for (int c = 0; c < 8; c++) begin
         if (c != 3'b110) begin
            if (c[1]) ie_set = 1'b1; else ie_clr = 1'b1;
            step();
            ie_set = 1'b0; ie_clr = 1'b0;
            int_req = c[2]; busreq = c[0]; end_instr = 1'b1;
            step();
            int_req = 1'b0; busreq = 1'b0; end_instr = 1'b0;
            check(c[1] ? "R4 busreq blocks" : "R3 disabled blocks", strobes(), 5'b00000);
            check("R3 R4 ie unchanged", ie_flag, c[1]);
            step();
            check("R2 still idle", strobes(), 5'b00000);
         end
      end

      // R6, R7, R8, R9, R12: acknowledge with 0..3 extra wait states
      for (int e = 0; e < 4; e++) begin
         enable_ie();
         run_ack(e, 16'h4000 + 16'(e * 16'h0111), 8'hA0 + 8'(e * 8'h13));
      end

      // R11: ie_clr
      enable_ie();
      ie_clr = 1'b1;
      step();
      ie_clr = 1'b0;
      check("R11 ie_clr", ie_flag, 0);

      // R12: wrap of the low 7 bits with bit 7 set and with bit 7 clear
      rfsh_load = 1'b1; rfsh_load_val = 8'hFF;
      step();
      rfsh_load = 1'b0;
      r_exp = 8'hFF;
      check("R12 load", rfsh_val, 8'hFF);
      enable_ie();
      run_ack(0, 16'hBEEF, 8'h5A);
      check("R12 top bit kept", rfsh_val, 8'h80);
      rfsh_load = 1'b1; rfsh_load_val = 8'h7F;
      step();
      rfsh_load = 1'b0;
      r_exp = 8'h7F;
      enable_ie();
      run_ack(1, 16'h0FF0, 8'hC3);
      check("R12 wrap top clear", rfsh_val, 8'h00);

      summary();
      $finish;
   end

endmodule